// File: doc/BRIEF.md
# Upward-Growing Byte Stack Engine

This block keeps the stack pointer of a small microcontroller core and performs single-byte push and pop operations on a 256-byte data RAM held inside the block. The stack grows toward higher addresses. The pointer always names the most recently filled byte. A push therefore moves the pointer up before it writes. A pop reads at the pointer and then moves it down.

The core starts an operation by raising `push_req` (with `push_data`) or `pop_req` for one cycle while the engine is idle. Each operation takes two clocks and ends with a one-cycle `done` pulse. Software may load the pointer at any time through `sp_load` and `sp_load_val`. A load has the highest priority and cancels any operation that is still in progress.

Top module: `byte_stack_engine`

## Requirements
- R1: The pointer `sp` is 8 bits wide and can hold any value 00h to FFh. A load sets it to the loaded value, and the pointer keeps its value while nothing acts on it.
- R2: While `rst_n` is low and after reset, `sp` reads 07h, `done` reads 0 and `pop_data` reads 00h, so the first push after reset stores its byte at address 08h.
- R3: The pointer addresses the last byte written. A pop that follows a push returns the byte just pushed.
- R4: A push request taken in idle raises `sp` by one at the first clock edge. At the second edge the held byte is written at the new `sp` address.
- R5: A pop request taken in idle puts the byte at the current `sp` address on `pop_data` at the first clock edge. `sp` drops by one at the second edge. `pop_data` holds its value until the next pop.
- R6: Each completed push or pop changes `sp` by exactly one. No other change happens without a load.
- R7: The pointer wraps modulo 256. A push at FFh moves it to 00h, a pop at 00h moves it to FFh, and no error is raised.
- R8: When push and pop are requested in the same idle cycle, the push is performed and the pop is ignored.
- R9: A load (`sp_load` = 1) sets `sp` at the next clock edge. It overrides a push or pop requested in the same cycle. It also cancels an operation already in progress, with no RAM write and no `done` for that operation.
- R10: `done` is high for exactly one cycle, right after the second edge of every operation that was not cancelled.
- R11: Push or pop requests arriving while an operation is in progress are ignored. The engine is idle again after the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| push_req | input | 1 | Start a push (sampled while idle) |
| push_data | input | 8 | Byte to push, sampled with `push_req` |
| pop_req | input | 1 | Start a pop (sampled while idle) |
| sp_load | input | 1 | Load the stack pointer |
| sp_load_val | input | 8 | Value loaded into the stack pointer |
| pop_data | output | 8 | Last byte read by a pop |
| sp | output | 8 | Current stack pointer |
| done | output | 1 | One-cycle end-of-operation strobe |

## Verification
The assertions check on every cycle:
- the reset value of the pointer;
- that a load takes effect;
- the step of one per completed operation;
- push priority on a simultaneous request;
- the one-cycle shape of `done` and that the engine always returns to idle after two clocks.

Only the bench's scenarios can show the data path. That covers whether a pop returns the right byte from the right address, whether a cancelled push left the RAM untouched, and whether the byte pushed across the FFh/00h wrap is read back correctly.

// File: rtl/stk_pkg.sv
// Shared types for the byte stack engine.
// Assumes: used by the sequencer and the pointer register only.
package stk_pkg;

    // Phase of the two-clock operation.
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PUSH_WR = 2'd1,
        ST_POP_DEC = 2'd2
    } stk_state_e;

    // Action applied to the stack pointer at the next edge.
    typedef enum logic [1:0] {
        PTR_HOLD = 2'd0,
        PTR_INC  = 2'd1,
        PTR_DEC  = 2'd2,
        PTR_LOAD = 2'd3
    } stk_ptr_op_e;

endpackage

// File: rtl/stk_ptr.sv
// Stack pointer register.
// Applies one of hold / increment / decrement / load per clock.
// Wraps modulo 2**AW with no error.
// Assumes: the sequencer supplies a single operation code per cycle.
module stk_ptr #(
    parameter int AW        = 8,
    parameter int RESET_VAL = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  stk_pkg::stk_ptr_op_e   op,
    input  logic [AW-1:0]          load_val,
    output logic [AW-1:0]          ptr
);
    import stk_pkg::*;

    localparam logic [AW-1:0] ONE  = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [AW-1:0] INIT = AW'(RESET_VAL);

    logic [AW-1:0] ptr_q;
    logic [AW-1:0] ptr_d;

    // Select the next pointer value from the requested operation.
    always_comb begin
        unique case (op)
            PTR_INC:  ptr_d = ptr_q + ONE;
            PTR_DEC:  ptr_d = ptr_q - ONE;
            PTR_LOAD: ptr_d = load_val;
            default:  ptr_d = ptr_q;
        endcase
    end

    // Register the pointer with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= INIT;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/stk_ram.sv
// Synchronous single-clock data RAM, 2**AW words of DW bits.
// One write port and one read port with a registered read output.
// The read register holds its value until the next read and resets to zero.
// The array itself is not reset.
// Assumes: the write and read addresses are never both active in one cycle.
module stk_ram #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    // Store a byte on a write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Capture the addressed byte on a read strobe; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_q <= '0;
        else if (re) rdata_q <= mem[raddr];
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/stk_seq.sv
// Operation sequencer for the stack engine.
// - Push: pointer increment first, RAM write second.
// - Pop: RAM read first, pointer decrement second.
// - A pointer load overrides everything and cancels an operation in flight.
// - Push wins over pop when both are requested.
// Assumes: requests are only sampled in the idle phase.
module stk_seq #(
    parameter int DW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push_req,
    input  logic [DW-1:0]         push_data,
    input  logic                  pop_req,
    input  logic                  sp_load,
    output stk_pkg::stk_ptr_op_e  ptr_op,
    output logic                  ram_we,
    output logic                  ram_re,
    output logic [DW-1:0]         wr_byte,
    output logic                  done,
    output logic                  idle
);
    import stk_pkg::*;

    stk_state_e    state_q, state_d;
    logic [DW-1:0] hold_q;
    logic          done_q;
    logic          take_push;

    assign idle      = (state_q == ST_IDLE);
    assign take_push = idle && push_req && !sp_load;

    // Decide the pointer action, RAM strobes and next phase.
    always_comb begin
        state_d = state_q;
        ptr_op  = PTR_HOLD;
        ram_we  = 1'b0;
        ram_re  = 1'b0;
        if (sp_load) begin
            ptr_op  = PTR_LOAD;
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (push_req) begin
                        ptr_op  = PTR_INC;
                        state_d = ST_PUSH_WR;
                    end else if (pop_req) begin
                        ram_re  = 1'b1;
                        state_d = ST_POP_DEC;
                    end
                end
                ST_PUSH_WR: begin
                    ram_we  = 1'b1;
                    state_d = ST_IDLE;
                end
                ST_POP_DEC: begin
                    ptr_op  = PTR_DEC;
                    state_d = ST_IDLE;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Advance the phase and raise the completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= !sp_load && (state_q != ST_IDLE);
        end
    end

    // Hold the pushed byte until the write phase.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_q <= '0;
        else if (take_push) hold_q <= push_data;
    end

    assign wr_byte = hold_q;
    assign done    = done_q;

endmodule

// File: rtl/byte_stack_engine.sv
// Top of the upward-growing byte stack engine.
// Ties the sequencer, the pointer register and the internal RAM together.
// Assumes: one operation at a time; the core waits for done before the next.
module byte_stack_engine #(
    parameter int AW        = 8,
    parameter int DW        = 8,
    parameter int RESET_SP  = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    input  logic          sp_load,
    input  logic [AW-1:0] sp_load_val,
    output logic [DW-1:0] pop_data,
    output logic [AW-1:0] sp,
    output logic          done
);
    import stk_pkg::*;

    stk_ptr_op_e   ptr_op;
    logic          ram_we;
    logic          ram_re;
    logic [DW-1:0] wr_byte;
    logic [AW-1:0] sp_cur;
    logic          seq_idle;

    stk_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .push_data (push_data),
        .pop_req   (pop_req),
        .sp_load   (sp_load),
        .ptr_op    (ptr_op),
        .ram_we    (ram_we),
        .ram_re    (ram_re),
        .wr_byte   (wr_byte),
        .done      (done),
        .idle      (seq_idle)
    );

    stk_ptr #(.AW(AW), .RESET_VAL(RESET_SP)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (ptr_op),
        .load_val (sp_load_val),
        .ptr      (sp_cur)
    );

    stk_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (sp_cur),
        .wdata (wr_byte),
        .re    (ram_re),
        .raddr (sp_cur),
        .rdata (pop_data)
    );

    assign sp = sp_cur;

endmodule

// File: rtl/stk_checker.sv
// Temporal checks for the byte stack engine, bound to the top module.
// Assumes: idle is the sequencer's idle indication.
module stk_checker #(
    parameter int AW       = 8,
    parameter int RESET_SP = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          push_req,
    input logic          pop_req,
    input logic          sp_load,
    input logic [AW-1:0] sp_load_val,
    input logic [AW-1:0] sp,
    input logic          done,
    input logic          idle
);
    localparam logic [AW-1:0] ONE  = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [AW-1:0] INIT = AW'(RESET_SP);

    p_reset_sp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sp == INIT && !done));

    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sp_load |=> (sp == $past(sp_load_val) && !done));

    p_push_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && push_req && !sp_load) |=> (sp == $past(sp) + ONE));

    p_pop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && pop_req && !push_req && !sp_load) |=> (sp == $past(sp)));

    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!sp_load && !idle) |=> (sp == $past(sp) || sp == $past(sp) - ONE));

    p_priority_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && push_req && pop_req && !sp_load) |=> (!idle && sp == $past(sp) + ONE));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && !sp_load) |=> done);

    p_back_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> idle);

endmodule

bind byte_stack_engine stk_checker #(.AW(AW), .RESET_SP(RESET_SP)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_req    (push_req),
    .pop_req     (pop_req),
    .sp_load     (sp_load),
    .sp_load_val (sp_load_val),
    .sp          (sp),
    .done        (done),
    .idle        (seq_idle)
);

// File: tb/tb_byte_stack_engine.sv
module tb_byte_stack_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_req = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic       pop_req = 1'b0;
    logic       sp_load = 1'b0;
    logic [7:0] sp_load_val = 8'h00;
    logic [7:0] pop_data;
    logic [7:0] sp;
    logic       done;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    byte_stack_engine dut (
        .clk(clk), .rst_n(rst_n), .push_req(push_req), .push_data(push_data),
        .pop_req(pop_req), .sp_load(sp_load), .sp_load_val(sp_load_val),
        .pop_data(pop_data), .sp(sp), .done(done)
    );

    // Behavioural reference: memory of ints (-1 = never written), phase counter.
    int    mem [256];
    int    m_sp = 7;
    int    m_phase = 0;
    int    m_hold = 0;
    int    m_pop = 0;
    int    m_done = 0;
    string sp_tag = "R2";

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = -1;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sp = 7; m_phase = 0; m_pop = 0; m_done = 0; sp_tag = "R2";
        end else begin
            m_done = 0;
            if (sp_load) begin
                m_sp = int'(sp_load_val); m_phase = 0; sp_tag = "R9";
            end else if (m_phase == 0) begin
                if (push_req) begin
                    m_sp = (m_sp + 1) % 256; m_hold = int'(push_data); m_phase = 1;
                    sp_tag = pop_req ? "R8" : (m_sp == 0 ? "R7" : "R4");
                end else if (pop_req) begin
                    m_pop = mem[m_sp]; m_phase = 2; sp_tag = "R5";
                end else sp_tag = "R1";
            end else if (m_phase == 1) begin
                mem[m_sp] = m_hold; m_done = 1; m_phase = 0;
                sp_tag = (push_req || pop_req) ? "R11" : "R4";
            end else begin
                m_sp = (m_sp + 255) % 256; m_done = 1; m_phase = 0;
                sp_tag = (m_sp == 255) ? "R7" : "R6";
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk(sp_tag, int'(sp), m_sp);
            chk("R10", int'(done), m_done);
            if (m_pop >= 0) chk("R3", int'(pop_data), m_pop);
        end
    end

    task automatic cyc(input bit pu, input bit po, input bit ld,
                       input logic [7:0] d, input logic [7:0] lv);
        push_req = pu; pop_req = po; sp_load = ld; push_data = d; sp_load_val = lv;
        @(negedge clk);
        push_req = 0; pop_req = 0; sp_load = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] keep;
        repeat (3) @(negedge clk);
        chk("R2", int'(sp), 8'h07);
        chk("R2", int'(done), 0);
        chk("R2", int'(pop_data), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R2/R4: first push lands at 08h
        cyc(1, 0, 0, 8'hA5, 0);
        chk("R2", int'(sp), 8'h08);
        cyc(0, 0, 0, 0, 0);
        chk("R10", int'(done), 1);
        cyc(0, 0, 0, 0, 0);
        chk("R10", int'(done), 0);
        // R3/R5: pop returns last byte
        cyc(0, 1, 0, 0, 0);
        chk("R3", int'(pop_data), 8'hA5);
        chk("R5", int'(sp), 8'h08);
        cyc(0, 0, 0, 0, 0);
        chk("R5", int'(sp), 8'h07);
        // Several pushes then pops
        for (int i = 1; i <= 5; i++) begin cyc(1, 0, 0, 8'(i * 17), 0); cyc(0, 0, 0, 0, 0); end
        for (int i = 5; i >= 1; i--) begin
            cyc(0, 1, 0, 0, 0);
            chk("R3", int'(pop_data), i * 17);
            cyc(0, 0, 0, 0, 0);
        end
        chk("R6", int'(sp), 8'h07);
        // R8: simultaneous push and pop
        cyc(1, 1, 0, 8'h5A, 0);
        chk("R8", int'(sp), 8'h08);
        cyc(0, 0, 0, 0, 0);
        // R1/R7: wrap upward
        cyc(0, 0, 1, 0, 8'hFF);
        chk("R1", int'(sp), 8'hFF);
        cyc(1, 0, 0, 8'h3C, 0);
        chk("R7", int'(sp), 8'h00);
        cyc(0, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0);
        chk("R7", int'(pop_data), 8'h3C);
        cyc(0, 0, 0, 0, 0);
        chk("R7", int'(sp), 8'hFF);
        // R7: wrap downward
        cyc(0, 0, 1, 0, 8'h00);
        cyc(0, 1, 0, 0, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R7", int'(sp), 8'hFF);
        // R9: load cancels an in-flight push
        cyc(0, 0, 1, 0, 8'h20);
        cyc(1, 0, 0, 8'h11, 0);
        cyc(0, 0, 0, 0, 0);
        cyc(1, 0, 0, 8'h99, 0);
        cyc(0, 0, 1, 0, 8'h21);
        chk("R9", int'(done), 0);
        chk("R9", int'(sp), 8'h21);
        cyc(0, 1, 0, 0, 0);
        chk("R9", int'(pop_data), 8'h11);
        cyc(0, 0, 0, 0, 0);
        // R11: request while busy ignored
        keep = sp;
        cyc(1, 0, 0, 8'h44, 0);
        cyc(1, 1, 0, 8'h55, 0);
        cyc(0, 0, 0, 0, 0);
        chk("R11", int'(sp), int'(keep + 8'd1));
        cyc(0, 1, 0, 0, 0);
        chk("R11", int'(pop_data), 8'h44);
        cyc(0, 0, 0, 0, 0);
        // R9: load overrides same-cycle push
        cyc(1, 0, 1, 8'h66, 8'h40);
        chk("R9", int'(sp), 8'h40);
        cyc(0, 0, 0, 0, 0);
        chk("R9", int'(done), 0);
        // Random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            cyc(r < 45, (r >= 30) && (r < 85), r >= 96,
                8'($urandom), 8'($urandom_range(0, 255)));
        end
        finish_run();
    end

endmodule